// File: doc/BRIEF.md
# Multi-Sector Erase Collector

This block gathers the set of sectors that a sector-erase request should cover and decides when that erase may begin. The command interpreter hands it single-cycle pulses. One pulse loads a sector and carries that sector's index. The others report a command that is not a sector load, an erase-suspend command, or a falling edge of the write strobe. The block keeps one mask bit per sector and runs a quiet-window counter, measured in clock cycles, that starts again whenever the host touches the bus.

When the window runs out with no further activity, the block raises a one-cycle start pulse and freezes the mask for the erase engine. A suspend command that arrives while the window is still open ends the window at once. Any other command abandons the request. Completion of the erase is reported back on a done pulse, and the mask then clears for the next request.

Top module: `sector_erase_collector`

## Requirements
- R1: After reset the sector mask is all zeros, no start pulse is given and the window indicator reads high.
- R2: A sector load while idle sets exactly mask bit i for sector index i, and opens the window: the indicator reads low from the next cycle.
- R3: While the window is open, each further load ORs its bit into the mask. Sectors may arrive in any order, and loading a sector that is already set leaves the mask unchanged.
- R4: If no load and no strobe edge arrive for WINDOW_CYCLES consecutive cycles after the last restart, the start output pulses high for exactly one cycle. In that same cycle the indicator goes high.
- R5: A write-strobe falling edge during the open window restarts the quiet count without changing the mask.
- R6: Once the window has expired, further sector loads are ignored and the mask stays unchanged.
- R7: A suspend pulse while the window is open ends the window in the next cycle: the start pulse is given and the indicator goes high. A load in the same cycle is dropped.
- R8: An other-command pulse while the window is open or the erase is running clears the mask and returns to idle, with no start pulse.
- R9: An erase-done pulse while erasing clears the mask and returns to idle.
- R10: Priority in one cycle is other-command first, then suspend, then load or strobe edge. An other-command pulse alongside an idle load keeps the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Sector-erase load pulse |
| load_sector_i | input | SEC_W | Index of the sector being loaded |
| other_cmd_i | input | 1 | Pulse: a command other than a sector load or suspend |
| suspend_i | input | 1 | Erase-suspend command pulse |
| we_fall_i | input | 1 | Write-strobe falling-edge pulse |
| erase_done_i | input | 1 | Erase engine reports completion |
| sector_mask_o | output | SECTORS | One bit per sector selected for erase |
| erase_start_o | output | 1 | One-cycle pulse: erase may begin |
| window_expired_o | output | 1 | Low while loads are accepted |

## Verification
A wrong internal state in this block shows up at the ports within a cycle or two. A stuck or miscounted window counter moves the start pulse away from the cycle in which it is expected, and the indicator flips high at the wrong cycle along with it. A state that wrongly stays open lets an ignored load change the mask on the next edge. A state that fails to return to idle keeps a stale mask visible after an abort or a completion. The bench compares all three outputs against a cycle-level reference model after every clock. Any such divergence is therefore reported in the cycle it first appears.

// File: rtl/sector_erase_collector.sv
module sector_erase_collector #(
  parameter int SECTORS       = 8,
  parameter int WINDOW_CYCLES = 64,
  parameter int SEC_W         = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [SEC_W-1:0]   load_sector_i,
  input  logic               other_cmd_i,
  input  logic               suspend_i,
  input  logic               we_fall_i,
  input  logic               erase_done_i,
  output logic [SECTORS-1:0] sector_mask_o,
  output logic               erase_start_o,
  output logic               window_expired_o
);

  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_ERASE} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [SECTORS-1:0] mask;
  logic               start_q;

  wire [SECTORS-1:0] sec_bit = SECTORS'(1) << load_sector_i;
  wire restart  = load_i | we_fall_i;
  wire timeout  = (cnt == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      mask    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state)
        S_IDLE: if (load_i && !other_cmd_i) begin
          state <= S_OPEN;
          mask  <= sec_bit;
          cnt   <= '0;
        end
        S_OPEN: begin
          if (other_cmd_i) begin
            state <= S_IDLE;
            mask  <= '0;
          end else if (suspend_i || timeout) begin
            state   <= S_ERASE;
            start_q <= 1'b1;
          end else if (restart) begin
            cnt <= '0;
            if (load_i) mask <= mask | sec_bit;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ERASE: if (other_cmd_i || erase_done_i) begin
          state <= S_IDLE;
          mask  <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sector_mask_o    = mask;
  assign erase_start_o    = start_q;
  assign window_expired_o = (state != S_OPEN);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |=> !erase_start_o);

  p_start_with_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |-> window_expired_o && (sector_mask_o != '0));

  p_frozen_after_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE && !other_cmd_i && !erase_done_i) |=> $stable(sector_mask_o));

  p_suspend_ends_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_expired_o && suspend_i && !other_cmd_i) |=> erase_start_o);

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    other_cmd_i |=> (sector_mask_o == '0) && !erase_start_o);

  p_load_sets_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_expired_o && load_i && !other_cmd_i && !suspend_i) |=>
      ((sector_mask_o & $past(sec_bit)) != '0) &&
      ((sector_mask_o & $past(sector_mask_o)) == $past(sector_mask_o)));

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE && erase_done_i) |=> (sector_mask_o == '0));

endmodule

// File: tb/tb_sector_erase_collector.sv
module tb_sector_erase_collector;
  localparam int PERIOD = 10;
  localparam int N = 8;
  localparam int W = 10;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 0, oth = 0, susp = 0, wef = 0, done = 0;
  logic [SW-1:0] sec = '0;
  logic [N-1:0] mask;
  logic start, expired;

  int checks = 0, fails = 0;
  string tag = "R1";
  int m_st = 0, m_cnt = 0;
  logic [N-1:0] m_mask = '0;
  logic m_start = 0;

  always #(PERIOD/2) clk = ~clk;

  sector_erase_collector #(.SECTORS(N), .WINDOW_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_sector_i(sec),
    .other_cmd_i(oth), .suspend_i(susp), .we_fall_i(wef), .erase_done_i(done),
    .sector_mask_o(mask), .erase_start_o(start), .window_expired_o(expired));

  function automatic logic [N-1:0] onehot(input logic [SW-1:0] s);
    return N'(1) << s;
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic model_step();
    m_start = 0;
    case (m_st)
      0: if (load && !oth) begin m_st = 1; m_mask = onehot(sec); m_cnt = 0; end
      1: if (oth) begin m_st = 0; m_mask = '0; end
         else if (susp) begin m_st = 2; m_start = 1; end
         else if (load || wef) begin m_cnt = 0; if (load) m_mask |= onehot(sec); end
         else if (m_cnt == W-1) begin m_st = 2; m_start = 1; end
         else m_cnt++;
      default: if (oth || done) begin m_st = 0; m_mask = '0; end
    endcase
  endtask

  task automatic cyc(input logic l, input logic [SW-1:0] s, input logic o,
                     input logic su, input logic w, input logic d);
    @(negedge clk);
    load = l; sec = s; oth = o; susp = su; wef = w; done = d;
    @(posedge clk);
    #1;
    model_step();
    check(tag, 32'(mask), 32'(m_mask), "mask");
    check(tag, 32'(start), 32'(m_start), "start");
    check(tag, 32'(expired), 32'(m_st != 1), "expired");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'(mask), 0, "reset mask");
    check("R1", 32'(start), 0, "reset start");
    check("R1", 32'(expired), 1, "reset expired");
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    tag = "R2"; cyc(1, 5, 0, 0, 0, 0);
    check("R2", 32'(mask), 32'h20, "first load bit");
    check("R2", 32'(expired), 0, "window open");
    tag = "R3"; cyc(1, 2, 0, 0, 0, 0); cyc(1, 5, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
    check("R3", 32'(mask), 32'h25, "accumulated mask");
    tag = "R4"; idle(W - 1);
    check("R4", 32'(start), 0, "no start before window end");
    cyc(0, 0, 0, 0, 0, 0);
    check("R4", 32'(start), 1, "start at window end");
    tag = "R6"; cyc(1, 7, 0, 0, 0, 0);
    check("R6", 32'(mask), 32'h25, "load after expiry ignored");
    tag = "R9"; idle(2); cyc(0, 0, 0, 0, 0, 1);
    check("R9", 32'(mask), 0, "done clears");

    tag = "R5"; cyc(1, 3, 0, 0, 0, 0); idle(W - 2); cyc(0, 0, 0, 0, 1, 0);
    idle(W - 1);
    check("R5", 32'(start), 0, "strobe edge restarted window");
    check("R5", 32'(mask), 32'h08, "strobe edge keeps mask");
    cyc(0, 0, 0, 0, 0, 0);
    check("R5", 32'(start), 1, "start after restarted window");
    cyc(0, 0, 0, 0, 0, 1);

    tag = "R7"; cyc(1, 1, 0, 0, 0, 0); cyc(1, 6, 0, 1, 0, 0);
    check("R7", 32'(start), 1, "suspend ends window");
    check("R7", 32'(mask), 32'h02, "load with suspend dropped");
    tag = "R8"; cyc(0, 0, 1, 0, 0, 0);
    check("R8", 32'(mask), 0, "abort during erase clears");
    cyc(1, 4, 0, 0, 0, 0); cyc(0, 0, 1, 1, 0, 0);
    check("R8", 32'(start), 0, "abort in window gives no start");
    check("R8", 32'(expired), 1, "abort returns to idle");
    tag = "R10"; cyc(1, 4, 1, 0, 0, 0);
    check("R10", 32'(expired), 1, "abort beats idle load");
    idle(2);

    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r < 25, SW'($urandom), r == 99, r == 98, (r >= 25 && r < 35),
          r >= 96 && r < 98);
    end
    report();
  end
endmodule